// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is an SPI master that software drives through a small register port. Each register access takes a single cycle, and reads return data combinationally. The configuration register sets four things: the serial clock rate, the clock polarity and phase, the word size of 8 or 16 bits, and the bit order for each direction independently. The control register selects one chip-select line by number and asserts it through a separate enable bit. While a word transfer is running, a read-only busy bit in the same register reads one.

A write to the data-out register shifts out one word and at the same time captures one word from MISO. The received word appears in the data-in register, and the completion flag is set on the same clock edge. Software clears the flag by writing zero before it starts the next transfer. The chosen chip select stays low across any number of words until software clears the enable bit. That lets a command and its data run as one framed sequence.

The serial clock rate comes from a two-stage prescaler. The first stage is a linear factor from 1 to 15. The second is a power-of-two exponent from 0 to 7, and its lowest bit and its upper two bits sit in two separate configuration fields.

Top module: `spi_regmaster`

## Requirements
- R1: The divider D equals the linear factor cfg[3:0] times 2 to the power E, where the exponent E is {cfg[11:10], cfg[4]}. SCLK edges are spaced D core cycles apart, and a transfer of N bits holds busy for exactly 2·N·D cycles.
- R2: A linear factor of 0 acts as 1, so SCLK always runs.
- R3: SCLK rests at the polarity bit cfg[5].
  - With the phase bit cfg[6] clear, the first bit is on MOSI before the first edge, and data is sampled on leading edges.
  - With cfg[6] set, bits are driven on leading edges and sampled on trailing edges.
- R4: Bit cfg[7] clear gives 8-bit words and set gives 16-bit words. Each transfer makes exactly 2·N SCLK edges.
- R5: Bit cfg[8] set sends the word LSB first, and bit cfg[9] set receives it LSB first. When either bit is clear, that direction is MSB first.
- R6: A write to address 2 (data-out) starts a transfer. At completion, address 4 (flag) bit 0 reads 1 and address 3 (data-in) holds the received word. Both update on the same clock edge.
- R7: Writing zero to address 4 clears the completion flag.
- R8: Address 1 bit 9 (busy) reads 1 for the whole transfer. A data-out write while busy is ignored.
- R9: Address 1 bits [1:0] select a line and bit 8 enables it. cs_n of the selected line is driven low while enabled, and it stays low across transfers. All other lines stay high.
- R10: After reset every register reads zero, SCLK is low and every chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 cfg, 1 ctrl, 2 data-out, 3 data-in, 4 flag) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The assertions check four things on every cycle:
- SCLK holds its level between prescaler ticks, and the prescaler count never reaches its limit.
- The edge counter stays inside the word, and a data-out write during a transfer leaves the shift state untouched.
- The data-in word changes only together with the completion flag.
- At most one chip select is low, and none is low while the enable bit is clear.

The remaining behaviour can only be shown by the bench scenarios. This covers the exact bit order on the wire for each mode, word size and direction, and the exact transfer length for every exponent and several linear factors. It also covers the zero-factor case, flag clearing, and chip-select persistence over many words.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;

   // register addresses
   typedef enum logic [2:0] {
      A_CFG  = 3'd0,
      A_CTRL = 3'd1,
      A_DOUT = 3'd2,
      A_DIN  = 3'd3,
      A_FLAG = 3'd4
   } reg_addr_e;

   // configuration layout, LSB first: lin[3:0], exp_lo[4], cpol[5],
   // cpha[6], wide[7], tx_lsb[8], rx_lsb[9], exp_hi[11:10]
   typedef struct packed {
      logic [1:0] exp_hi;
      logic       rx_lsb;
      logic       tx_lsb;
      logic       wide;
      logic       cpha;
      logic       cpol;
      logic       exp_lo;
      logic [3:0] lin;
   } cfg_t;

   localparam int unsigned CFG_W   = $bits(cfg_t);
   localparam int unsigned CT_EN   = 8;
   localparam int unsigned CT_BUSY = 9;

endpackage

// File: rtl/spi_clk_divider.sv
module spi_clk_divider #(
   parameter int unsigned LIN_W = 4,
   parameter int unsigned EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [LIN_W-1:0] lin,
   input  logic [EXP_W-1:0] expo,
   output logic             tick
);
   localparam int unsigned DIV_W = LIN_W + (1 << EXP_W) - 1;

   generate
      if (LIN_W < 1 || EXP_W < 1 || EXP_W > 5) begin : g_bad_cfg
         $error("spi_clk_divider: LIN_W must be >= 1 and EXP_W in 1..5");
      end
   endgenerate

   logic [LIN_W-1:0] lin_eff;
   logic [DIV_W-1:0] div_now, div_q, cnt_q;

   assign lin_eff = (lin == '0) ? LIN_W'(1) : lin;
   assign div_now = DIV_W'(lin_eff) << expo;
   assign tick    = run && (cnt_q == div_q - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= DIV_W'(1);
      end else begin
         if (!run) div_q <= div_now;   // frozen while a transfer runs
         if (!run || tick) cnt_q <= '0;
         else              cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   // R1: count stays below the latched divider
   p_cnt_below_div_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < div_q));
   // R2: the latched divider is never zero
   p_div_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      div_q != '0);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              wide,
   input  logic              tx_lsb,
   input  logic              rx_lsb,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   output logic              done,
   output logic [WORD_W-1:0] rx_word
);
   localparam int unsigned HALF  = WORD_W / 2;
   localparam int unsigned CNT_W = $clog2(2 * WORD_W) + 1;

   generate
      if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_bad_width
         $error("spi_shift_engine: WORD_W must be even and >= 4");
      end
   endgenerate

   function automatic logic [WORD_W-1:0] rev(input logic [WORD_W-1:0] v);
      logic [WORD_W-1:0] r;
      for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
      return r;
   endfunction

   logic              busy_q, phase_q, mosi_q;
   logic              l_cpol, l_cpha, l_wide, l_rxlsb;
   logic [CNT_W-1:0]  edge_q, nedges;
   logic [WORD_W-1:0] tx_sr, rx_sr, rx_q, aligned, rx_next, rx_ord, low_mask;
   logic              is_sample, is_drive, is_last;

   assign nedges    = l_wide ? CNT_W'(2 * WORD_W) : CNT_W'(WORD_W);
   assign is_sample = busy_q && tick && (edge_q[0] == l_cpha);
   assign is_drive  = busy_q && tick && (edge_q[0] != l_cpha);
   assign is_last   = busy_q && tick && (edge_q == nedges - CNT_W'(1));
   assign low_mask  = (WORD_W'(1) << HALF) - WORD_W'(1);

   // transmit word placed so the first bit out is the top bit
   assign aligned = tx_lsb ? rev(tx_word) : (wide ? tx_word : (tx_word << HALF));

   assign rx_next = is_sample ? {rx_sr[WORD_W-2:0], miso} : rx_sr;

   always_comb begin
      if (l_rxlsb) rx_ord = l_wide ? rev(rx_next) : rev(rx_next << HALF);
      else         rx_ord = l_wide ? rx_next : (rx_next & low_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         mosi_q  <= 1'b0;
         edge_q  <= '0;
         tx_sr   <= '0;
         rx_sr   <= '0;
         rx_q    <= '0;
         l_cpol  <= 1'b0;
         l_cpha  <= 1'b0;
         l_wide  <= 1'b0;
         l_rxlsb <= 1'b0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            edge_q  <= '0;
            rx_sr   <= '0;
            l_cpol  <= cpol;
            l_cpha  <= cpha;
            l_wide  <= wide;
            l_rxlsb <= rx_lsb;
            if (cpha) begin
               mosi_q <= 1'b0;
               tx_sr  <= aligned;
            end else begin
               mosi_q <= aligned[WORD_W-1];
               tx_sr  <= aligned << 1;
            end
         end
      end else if (tick) begin
         phase_q <= ~phase_q;
         edge_q  <= edge_q + CNT_W'(1);
         rx_sr   <= rx_next;
         if (is_drive) begin
            mosi_q <= tx_sr[WORD_W-1];
            tx_sr  <= tx_sr << 1;
         end
         if (is_last) begin
            busy_q <= 1'b0;
            rx_q   <= rx_ord;
         end
      end
   end

   assign busy    = busy_q;
   assign sclk    = busy_q ? (l_cpol ^ phase_q) : cpol;
   assign mosi    = mosi_q;
   assign done    = is_last;
   assign rx_word = rx_q;

   // R1: SCLK only moves on a prescaler tick
   p_sclk_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !tick) |=> $stable(sclk));
   // R4: edge counter never passes the word's edge count
   p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (edge_q < nedges));
   // R8: a start request during a transfer leaves the shift state alone
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start && !tick) |=> ($stable(edge_q) && $stable(tx_sr) && busy_q));

endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
   parameter int unsigned NUM_CS = 4,
   parameter int unsigned SEL_W  = 2
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [NUM_CS-1:0] cs_n
);
   generate
      if (NUM_CS < 1 || (1 << SEL_W) < NUM_CS) begin : g_bad_sel
         $error("spi_cs_decode: SEL_W too narrow for NUM_CS");
      end
      for (genvar g = 0; g < NUM_CS; g++) begin : g_line
         assign cs_n[g] = !(en && (sel == SEL_W'(g)));
      end
   endgenerate
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
   import spi_regmaster_pkg::*;
#(
   parameter int unsigned NUM_CS = 4,
   parameter int unsigned REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs_n
);
   localparam int unsigned WORD_W = 16;
   localparam int unsigned SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   generate
      if (REG_W < 16) begin : g_bad_regw
         $error("spi_regmaster: REG_W must be at least 16");
      end
      if (SEL_W > CT_EN) begin : g_bad_ncs
         $error("spi_regmaster: NUM_CS too large for control layout");
      end
   endgenerate

   cfg_t              cfg_q;
   logic [SEL_W-1:0]  sel_q;
   logic              en_q, flag_q;
   logic              start, busy, done;
   logic              tick;
   logic [WORD_W-1:0] rx_word;

   assign start = reg_wr && (reg_addr == A_DOUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         sel_q  <= '0;
         en_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               A_CFG:  cfg_q <= cfg_t'(reg_wdata[CFG_W-1:0]);
               A_CTRL: begin
                  sel_q <= reg_wdata[SEL_W-1:0];
                  en_q  <= reg_wdata[CT_EN];
               end
               A_FLAG: if (reg_wdata == '0) flag_q <= 1'b0;
               default: ;
            endcase
         end
         if (done) flag_q <= 1'b1;   // completion wins over a same-cycle clear
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CFG:  reg_rdata[CFG_W-1:0] = cfg_q;
         A_CTRL: begin
            reg_rdata[SEL_W-1:0] = sel_q;
            reg_rdata[CT_EN]     = en_q;
            reg_rdata[CT_BUSY]   = busy;
         end
         A_DIN:  reg_rdata[WORD_W-1:0] = rx_word;
         A_FLAG: reg_rdata[0] = flag_q;
         default: ;
      endcase
   end

   spi_clk_divider #(.LIN_W(4), .EXP_W(3)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .lin   (cfg_q.lin),
      .expo  ({cfg_q.exp_hi, cfg_q.exp_lo}),
      .tick  (tick)
   );

   spi_shift_engine #(.WORD_W(WORD_W)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tx_word (reg_wdata[WORD_W-1:0]),
      .cpol    (cfg_q.cpol),
      .cpha    (cfg_q.cpha),
      .wide    (cfg_q.wide),
      .tx_lsb  (cfg_q.tx_lsb),
      .rx_lsb  (cfg_q.rx_lsb),
      .tick    (tick),
      .miso    (spi_miso),
      .busy    (busy),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .done    (done),
      .rx_word (rx_word)
   );

   spi_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
      .en   (en_q),
      .sel  (sel_q),
      .cs_n (spi_cs_n)
   );

   // R6: end of a transfer always leaves the flag set
   p_flag_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> flag_q);
   // R6: data-in only moves together with a set flag
   p_din_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word) |-> flag_q);
   // R9: at most one line low
   p_cs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~spi_cs_n));
   // R9: no line low while the enable is clear
   p_cs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (&spi_cs_n));

endmodule

// File: tb/sim_spi_regmaster.sv
module sim_spi_regmaster;
   localparam int CLK_NS = 10;
   localparam int NCS    = 4;
   localparam logic [2:0] A_CFG = 3'd0, A_CTRL = 3'd1, A_DOUT = 3'd2,
                          A_DIN = 3'd3, A_FLAG = 3'd4;

   logic        clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        sclk, mosi, miso;
   logic [NCS-1:0] cs_n;

   always #(CLK_NS/2) clk = ~clk;

   spi_regmaster #(.NUM_CS(NCS), .REG_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .spi_sclk(sclk),
      .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n));

   int n_run = 0, n_fail = 0;

   task automatic check(input string msg, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
      end
   endtask

   // device model
   logic        sl_cpol = 0, sl_cpha = 0, sl_rxlsb = 0, prev_sclk = 0;
   int          sl_edges = 0, sl_idx = 0, sl_n = 8;
   logic [15:0] sl_m = '0;
   logic [31:0] sl_rx = '0;

   always @(negedge clk) begin
      if (rst_n && sclk !== prev_sclk) begin
         sl_edges++;
         if ((sclk != sl_cpol) == !sl_cpha) begin
            sl_rx = {sl_rx[30:0], mosi};
            sl_idx++;
         end
      end
      prev_sclk = sclk;
   end

   always_comb begin
      miso = 1'b0;
      if (sl_idx < sl_n) miso = sl_rxlsb ? sl_m[sl_idx] : sl_m[sl_n-1-sl_idx];
   end

   task automatic wreg(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [15:0] v);
      addr = a; #1; v = rdata;
   endtask

   function automatic logic [15:0] mk(int lin, int e, bit cpol, bit cpha, bit wide, bit txl, bit rxl);
      logic [2:0] ee = 3'(e);
      return {4'b0, ee[2:1], rxl, txl, wide, cpha, cpol, ee[0], 4'(lin)};
   endfunction

   task automatic xfer(input int lin, input int e, input bit cpol, input bit cpha,
                       input bit wide, input bit txl, input bit rxl,
                       input logic [15:0] tx, input logic [15:0] m, input bit inject,
                       input string tag);
      int n, nb, d;
      logic [15:0] v, ex_rx, mask;
      nb   = wide ? 16 : 8;
      d    = (lin == 0 ? 1 : lin) << e;
      mask = wide ? 16'hFFFF : 16'h00FF;
      ex_rx = '0;
      for (int i = 0; i < nb; i++) ex_rx[nb-1-i] = txl ? tx[i] : tx[nb-1-i];
      wreg(A_CFG, mk(lin, e, cpol, cpha, wide, txl, rxl));
      @(negedge clk);
      check($sformatf("%s R3 idle level", tag), 32'(sclk), 32'(cpol));
      sl_edges = 0; sl_idx = 0; sl_rx = '0; sl_n = nb; sl_rxlsb = rxl;
      sl_m = m; sl_cpol = cpol; sl_cpha = cpha;
      @(negedge clk); addr = A_DOUT; wdata = tx; wr = 1'b1;
      n = 0;
      forever begin
         @(negedge clk); wr = 1'b0; addr = A_CTRL; #1;
         if (!rdata[9]) break;
         n++;
         if (inject && n == 3) begin addr = A_DOUT; wdata = ~tx; wr = 1'b1; end
      end
      check($sformatf("%s R1 R8 busy cycles", tag), 32'(n), 32'(2*nb*d));
      check($sformatf("%s R4 edge count", tag), 32'(sl_edges), 32'(2*nb));
      check($sformatf("%s R3 R5 bits on MOSI", tag), sl_rx & 32'(mask), 32'(ex_rx));
      rreg(A_FLAG, v);
      check($sformatf("%s R6 flag set", tag), 32'(v), 32'd1);
      rreg(A_DIN, v);
      check($sformatf("%s R6 R5 data-in", tag), 32'(v), 32'(m & mask));
      wreg(A_FLAG, 16'h0);
      rreg(A_FLAG, v);
      check($sformatf("%s R7 flag cleared", tag), 32'(v), 32'd0);
   endtask

   initial begin : wdog
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      int lins[5] = '{0, 1, 2, 3, 5};
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 cs_n after reset", 32'(cs_n), 32'hF);
      check("R10 sclk after reset", 32'(sclk), 32'd0);
      rreg(A_CFG, v);  check("R10 cfg after reset", 32'(v), 32'd0);
      rreg(A_CTRL, v); check("R10 ctrl after reset", 32'(v), 32'd0);
      rreg(A_FLAG, v); check("R10 flag after reset", 32'(v), 32'd0);
      rreg(A_DIN, v);  check("R10 data-in after reset", 32'(v), 32'd0);

      wreg(A_CTRL, 16'h0102);
      @(negedge clk);
      check("R9 line 2 selected", 32'(cs_n), 32'hB);
      rreg(A_CTRL, v);
      check("R9 ctrl readback", 32'(v), 32'h0102);

      k = 0;
      for (int md = 0; md < 4; md++)
         for (int w = 0; w < 2; w++)
            for (int o = 0; o < 4; o++) begin
               xfer(1, 1, md[1], md[0], w[0], o[0], o[1],
                    16'h9C35 ^ 16'(k * 16'h1111), 16'h6A0F + 16'(k * 16'h0B37), 1'b0,
                    $sformatf("mode%0d w%0d ord%0d", md, w, o));
               k++;
            end
      check("R9 line held across transfers", 32'(cs_n), 32'hB);

      xfer(2, 1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hB00C, 16'h1357, 1'b1, "R8 write while busy");

      foreach (lins[i])
         for (int e = 0; e < 8; e++)
            xfer(lins[i], e, e[0], e[1], 1'b0, 1'b0, 1'b0, 16'h00A5 + 16'(e), 16'h003C ^ 16'(i),
                 1'b0, $sformatf("R1 R2 lin%0d exp%0d", lins[i], e));
      xfer(15, 7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0081, 16'h00E7, 1'b0, "R1 max divider");

      wreg(A_CTRL, 16'h0003);
      @(negedge clk);
      check("R9 enable clear keeps all high", 32'(cs_n), 32'hF);
      wreg(A_CTRL, 16'h0100);
      @(negedge clk);
      check("R9 line 0 selected", 32'(cs_n), 32'hE);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule